// File: doc/BRIEF.md
# ALU Group Read-Port Conflict Checker

This block inspects instruction groups for a five-slot VLIW ALU. The group has four vector slots and one transcendental slot, and it reaches the block as a stream of slot words, one per cycle. Each slot word carries the following:

- up to three source operands;
- for each source, a register-or-constant select, a component index and a two-bit read-cycle digit;
- a flag that marks the transcendental slot;
- a flag that closes the group.

General-purpose registers are read over a window of three cycles. Each of the four component banks can deliver only one register per cycle. The block assigns every operand its read cycle and records which register holds each bank port in each cycle. It also keeps the distinct GPR numbers and distinct constant components seen so far in the group.

The cycle after the closing slot is accepted, the block gives one verdict for the whole group. The verdict is either legal or a single reason code. The accumulated state is then cleared for the next group. Instruction execution, result writeback and indexed addressing are not part of this block.

Top module: `alu_group_port_check`

## Requirements
- R1: `verdict_valid` is high for exactly the one cycle after a slot is accepted with `slot_valid` and `slot_last` both set, and is low in every other cycle. While `verdict_valid` is low, `verdict_ok` and `verdict_reason` are 0.
- R2: After a synchronous active-low reset, no verdict is pending and the group state is empty.
- R3: Source select decoding is as follows. 0-127 is a GPR, with the bank equal to the component index. 128-191 is a constant-cache entry. 192-253 is an inline constant. 254-255 is a previous-result operand. Only GPR operands use bank read ports.
- R4: Source i takes its read cycle from bits [2i+1:2i] of `slot_swz`. The value 3 on any active, non-squared source gives reason 5 (bad swizzle).
- R5: Reason 1 (port conflict) is reported when two port-using operands anywhere in the group, including the transcendental slot, have the same cycle and the same component but different registers. Operands with the same register, component and cycle share one read.
- R6: When sources 0 and 1 of a slot are both active GPRs with the same select and component, source 1 uses no port and its cycle digit is ignored.
- R7: Reason 2 (too many GPRs) is reported when a group names more than 3 distinct GPR numbers.
- R8: Reason 3 (too many constants) is reported when a group names more than 4 distinct constant-cache components, where a component is a select and component index pair.
- R9: The constant count of a transcendental slot is its number of operands with select 128-253. With exactly one such constant, a GPR or previous-result read in cycle 0 gives reason 4 (trans timing). With exactly two, any such read outside cycle 2 gives reason 4.
- R10: When several faults occur, the reason reported is the highest in this order: 5, 1, 2, 3, 4. A legal group gives reason 0 with `verdict_ok` high.
- R11: Only the first `slot_nsrc` sources of a slot are examined. The fields of the remaining sources have no effect.
- R12: Nothing carries over between groups. A legal group that follows a faulty one reports reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | 1 | A slot word is present this cycle |
| slot_last | input | 1 | This slot closes the group |
| slot_trans | input | 1 | This slot is the transcendental slot |
| slot_nsrc | input | 2 | Number of active sources (0-3) |
| slot_sel | input | 24 | Source selects, 8 bits each, source 0 in the low bits |
| slot_elem | input | 6 | Source component indices, 2 bits each |
| slot_swz | input | 6 | Source read-cycle digits, 2 bits each |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_ok | output | 1 | The group is legal |
| verdict_reason | output | 3 | 0 ok, 1 port, 2 GPRs, 3 constants, 4 trans timing, 5 bad swizzle |

## Verification
The verdict is produced by a single register stage. It is therefore due in the cycle right after the edge that accepts the closing slot, and it must be gone one cycle later. The bench drives slot words on falling edges. After the closing slot it waits exactly one falling edge, then compares the valid strobe, the reason code and the ok flag. On the next falling edge it checks that the strobe has dropped. Non-closing slots produce no output, so there is nothing to sample for them. The expected reason is worked out from the group the bench itself built. It is compared against a pairwise model of conflicts and distinct counts, which is a different algorithm from the design's incremental port table.

// File: rtl/agc_pkg.sv
// Package: shared types for the ALU group read-port checker.
// Assumes 8-bit source selects and 2-bit component and cycle fields.
package agc_pkg;
    localparam int SEL_W  = 8;
    localparam int ELEM_W = 2;
    localparam int CYC_W  = 2;

    localparam logic [SEL_W-1:0] CONST_LO  = 8'd128;
    localparam logic [SEL_W-1:0] INLINE_LO = 8'd192;
    localparam logic [SEL_W-1:0] PREV_LO   = 8'd254;

    typedef enum logic [1:0] {K_GPR, K_CONST, K_INLINE, K_PREV} kind_e;

    typedef struct packed {
        logic              act;
        logic              skip;
        kind_e             kind;
        logic [SEL_W-1:0]  sel;
        logic [ELEM_W-1:0] elem;
        logic [CYC_W-1:0]  cyc;
        logic              cyc_ok;
        logic              port;
    } opnd_t;

    typedef enum logic [2:0] {
        RS_OK = 3'd0, RS_PORT = 3'd1, RS_GPRS = 3'd2,
        RS_CONST = 3'd3, RS_TRANS = 3'd4, RS_SWZ = 3'd5
    } reason_e;

    localparam int ERR_PORT  = 0;
    localparam int ERR_GPRS  = 1;
    localparam int ERR_CONST = 2;
    localparam int ERR_TRANS = 3;
    localparam int ERR_SWZ   = 4;
    localparam int NERR      = 5;

    // Map a source select onto its operand class.
    function automatic kind_e classify(input logic [SEL_W-1:0] s);
        if (s < CONST_LO)       return K_GPR;
        else if (s < INLINE_LO) return K_CONST;
        else if (s < PREV_LO)   return K_INLINE;
        else                    return K_PREV;
    endfunction
endpackage

// File: rtl/agc_opnd_decode.sv
// Module: decodes the sources of one slot word into operand records.
// It handles squaring detection, read-cycle digits, bad digits and the
// transcendental-slot timing rule. The logic is purely combinational.
// Assumes squaring is only ever between source 0 and source 1.
module agc_opnd_decode
    import agc_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int NCYC = 3
) (
    input  logic                           trans,
    input  logic [$clog2(NSRC+1)-1:0]      nsrc,
    input  logic [NSRC*SEL_W-1:0]          sel,
    input  logic [NSRC*ELEM_W-1:0]         elem,
    input  logic [NSRC*CYC_W-1:0]          swz,
    output opnd_t [NSRC-1:0]               ops,
    output logic                           bad_swz,
    output logic                           trans_viol
);
    localparam int NS_W = $clog2(NSRC+1);

    logic [NS_W-1:0] ncon;
    logic [NSRC-1:0] bad_v;
    logic [NSRC-1:0] viol_v;

    // Count the constant operands (cache or inline) among the active sources.
    always_comb begin
        ncon = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (NS_W'(i) < nsrc &&
                (classify(sel[i*SEL_W +: SEL_W]) == K_CONST ||
                 classify(sel[i*SEL_W +: SEL_W]) == K_INLINE))
                ncon = ncon + NS_W'(1);
        end
    end

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        opnd_t o;
        logic  sq;
        if (gi == 1) begin : g_sq
            // Source 1 repeats source 0 (same GPR component): no port needed.
            assign sq = (nsrc > NS_W'(1)) &&
                        classify(sel[0 +: SEL_W]) == K_GPR &&
                        sel[0 +: SEL_W] == sel[SEL_W +: SEL_W] &&
                        elem[0 +: ELEM_W] == elem[ELEM_W +: ELEM_W];
        end else begin : g_nosq
            assign sq = 1'b0;
        end

        // Build the operand record for this source.
        always_comb begin
            o        = '0;
            o.act    = NS_W'(gi) < nsrc;
            o.skip   = sq;
            o.kind   = classify(sel[gi*SEL_W +: SEL_W]);
            o.sel    = sel[gi*SEL_W +: SEL_W];
            o.elem   = elem[gi*ELEM_W +: ELEM_W];
            o.cyc    = swz[gi*CYC_W +: CYC_W];
            o.cyc_ok = swz[gi*CYC_W +: CYC_W] < CYC_W'(NCYC);
            o.port   = o.act && !sq && o.cyc_ok && o.kind == K_GPR;
        end
        assign ops[gi] = o;

        // An active, non-squared source must name a real read cycle.
        assign bad_v[gi] = o.act && !sq && !o.cyc_ok;

        // Trans slot: restrict cycles of GPR / previous-result reads by constant count.
        assign viol_v[gi] = trans && o.act && !sq && o.cyc_ok &&
                            (o.kind == K_GPR || o.kind == K_PREV) &&
                            ((ncon == NS_W'(1) && o.cyc == CYC_W'(0)) ||
                             (ncon == NS_W'(2) && o.cyc != CYC_W'(2)));
    end

    assign bad_swz    = |bad_v;
    assign trans_viol = |viol_v;
endmodule

// File: rtl/agc_group_track.sv
// Module: accumulates per-group state (bank port owners per cycle, the
// distinct GPR list, the distinct constant list and sticky fault bits) and
// merges each accepted slot into it. State clears when the closing slot is
// accepted. Assumes the decode stage gives port=1 only for valid cycles.
module agc_group_track
    import agc_pkg::*;
#(
    parameter int NSRC       = 3,
    parameter int NCYC       = 3,
    parameter int NBANK      = 4,
    parameter int GPR_W      = 7,
    parameter int MAX_GPRS   = 3,
    parameter int MAX_CONSTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_valid,
    input  logic               slot_last,
    input  opnd_t [NSRC-1:0]   ops,
    input  logic               bad_swz,
    input  logic               trans_viol,
    output logic               grp_end,
    output logic [NERR-1:0]    grp_err
);
    localparam int GC_W  = $clog2(MAX_GPRS+1);
    localparam int CC_W  = $clog2(MAX_CONSTS+1);
    localparam int KEY_W = SEL_W + ELEM_W;

    logic [NCYC-1:0][NBANK-1:0]             busy_q, n_busy;
    logic [NCYC-1:0][NBANK-1:0][GPR_W-1:0]  reg_q, n_reg;
    logic [MAX_GPRS-1:0][GPR_W-1:0]         glist_q, n_glist;
    logic [GC_W-1:0]                        gcnt_q, n_gcnt;
    logic [MAX_CONSTS-1:0][KEY_W-1:0]       clist_q, n_clist;
    logic [CC_W-1:0]                        ccnt_q, n_ccnt;
    logic [NERR-1:0]                        err_q;
    logic conflict, g_over, c_over, hit;

    // Merge the current slot's operands into a copy of the group state.
    always_comb begin
        n_busy = busy_q; n_reg = reg_q;
        n_glist = glist_q; n_gcnt = gcnt_q;
        n_clist = clist_q; n_ccnt = ccnt_q;
        conflict = 1'b0; g_over = 1'b0; c_over = 1'b0; hit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            for (int c = 0; c < NCYC; c++) begin
                for (int b = 0; b < NBANK; b++) begin
                    if (ops[i].port && ops[i].cyc == CYC_W'(c) &&
                        ops[i].elem == ELEM_W'(b)) begin
                        if (n_busy[c][b] && n_reg[c][b] != ops[i].sel[GPR_W-1:0])
                            conflict = 1'b1;
                        else begin
                            n_busy[c][b] = 1'b1;
                            n_reg[c][b]  = ops[i].sel[GPR_W-1:0];
                        end
                    end
                end
            end
            if (ops[i].act && ops[i].kind == K_GPR) begin
                hit = 1'b0;
                for (int k = 0; k < MAX_GPRS; k++)
                    if (GC_W'(k) < n_gcnt && n_glist[k] == ops[i].sel[GPR_W-1:0])
                        hit = 1'b1;
                if (!hit) begin
                    if (n_gcnt < GC_W'(MAX_GPRS)) begin
                        for (int k = 0; k < MAX_GPRS; k++)
                            if (GC_W'(k) == n_gcnt) n_glist[k] = ops[i].sel[GPR_W-1:0];
                        n_gcnt = n_gcnt + GC_W'(1);
                    end else g_over = 1'b1;
                end
            end
            if (ops[i].act && ops[i].kind == K_CONST) begin
                hit = 1'b0;
                for (int k = 0; k < MAX_CONSTS; k++)
                    if (CC_W'(k) < n_ccnt && n_clist[k] == {ops[i].sel, ops[i].elem})
                        hit = 1'b1;
                if (!hit) begin
                    if (n_ccnt < CC_W'(MAX_CONSTS)) begin
                        for (int k = 0; k < MAX_CONSTS; k++)
                            if (CC_W'(k) == n_ccnt) n_clist[k] = {ops[i].sel, ops[i].elem};
                        n_ccnt = n_ccnt + CC_W'(1);
                    end else c_over = 1'b1;
                end
            end
        end
        grp_err            = err_q;
        grp_err[ERR_PORT]  = err_q[ERR_PORT]  | conflict;
        grp_err[ERR_GPRS]  = err_q[ERR_GPRS]  | g_over;
        grp_err[ERR_CONST] = err_q[ERR_CONST] | c_over;
        grp_err[ERR_TRANS] = err_q[ERR_TRANS] | trans_viol;
        grp_err[ERR_SWZ]   = err_q[ERR_SWZ]   | bad_swz;
    end

    assign grp_end = slot_valid && slot_last;

    // Hold group state between slots; clear on reset or at group end.
    always_ff @(posedge clk) begin
        if (!rst_n || grp_end) begin
            busy_q <= '0; reg_q <= '0;
            glist_q <= '0; gcnt_q <= '0;
            clist_q <= '0; ccnt_q <= '0;
            err_q <= '0;
        end else if (slot_valid) begin
            busy_q <= n_busy; reg_q <= n_reg;
            glist_q <= n_glist; gcnt_q <= n_gcnt;
            clist_q <= n_clist; ccnt_q <= n_ccnt;
            err_q <= grp_err;
        end
    end
endmodule

// File: rtl/agc_verdict.sv
// Module: turns the merged fault bits into one reason code by fixed
// priority and registers the one-cycle verdict. Assumes grp_end is a
// single-cycle qualifier for grp_err.
module agc_verdict
    import agc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grp_end,
    input  logic [NERR-1:0] grp_err,
    output logic            v_valid,
    output logic            v_ok,
    output reason_e         v_reason
);
    reason_e rsn;

    // Priority select: later lines override earlier ones.
    always_comb begin
        rsn = RS_OK;
        if (grp_err[ERR_TRANS]) rsn = RS_TRANS;
        if (grp_err[ERR_CONST]) rsn = RS_CONST;
        if (grp_err[ERR_GPRS])  rsn = RS_GPRS;
        if (grp_err[ERR_PORT])  rsn = RS_PORT;
        if (grp_err[ERR_SWZ])   rsn = RS_SWZ;
    end

    // Register the verdict for exactly one cycle after the group ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !grp_end) begin
            v_valid  <= 1'b0;
            v_ok     <= 1'b0;
            v_reason <= RS_OK;
        end else begin
            v_valid  <= 1'b1;
            v_ok     <= (rsn == RS_OK);
            v_reason <= rsn;
        end
    end
endmodule

// File: rtl/alu_group_port_check.sv
// Module: top of the ALU group read-port checker. Slot words stream in and
// one verdict per group leaves. Assumes slots are presented in their fixed
// order, with the transcendental slot last when it is present.
module alu_group_port_check
    import agc_pkg::*;
#(
    parameter int NSRC       = 3,
    parameter int NCYC       = 3,
    parameter int NBANK      = 4,
    parameter int GPR_W      = 7,
    parameter int MAX_GPRS   = 3,
    parameter int MAX_CONSTS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_valid,
    input  logic                          slot_last,
    input  logic                          slot_trans,
    input  logic [$clog2(NSRC+1)-1:0]     slot_nsrc,
    input  logic [NSRC*SEL_W-1:0]         slot_sel,
    input  logic [NSRC*ELEM_W-1:0]        slot_elem,
    input  logic [NSRC*CYC_W-1:0]         slot_swz,
    output logic                          verdict_valid,
    output logic                          verdict_ok,
    output logic [2:0]                    verdict_reason
);
    opnd_t [NSRC-1:0] ops;
    logic             bad_swz, trans_viol, grp_end;
    logic [NERR-1:0]  grp_err;
    reason_e          rsn_q;

    agc_opnd_decode #(.NSRC(NSRC), .NCYC(NCYC)) u_dec (
        .trans(slot_trans), .nsrc(slot_nsrc), .sel(slot_sel),
        .elem(slot_elem), .swz(slot_swz), .ops(ops),
        .bad_swz(bad_swz), .trans_viol(trans_viol)
    );

    agc_group_track #(
        .NSRC(NSRC), .NCYC(NCYC), .NBANK(NBANK), .GPR_W(GPR_W),
        .MAX_GPRS(MAX_GPRS), .MAX_CONSTS(MAX_CONSTS)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid),
        .slot_last(slot_last), .ops(ops), .bad_swz(bad_swz),
        .trans_viol(trans_viol), .grp_end(grp_end), .grp_err(grp_err)
    );

    agc_verdict u_vrd (
        .clk(clk), .rst_n(rst_n), .grp_end(grp_end), .grp_err(grp_err),
        .v_valid(verdict_valid), .v_ok(verdict_ok), .v_reason(rsn_q)
    );

    assign verdict_reason = rsn_q;
endmodule

// File: rtl/alu_group_port_check_sva.sv
// Checker: temporal properties on the ports of alu_group_port_check.
// Attached to the top module by the bind statement at the end of this file.
module alu_group_port_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_valid,
    input logic       slot_last,
    input logic [1:0] slot_nsrc,
    input logic [5:0] slot_swz,
    input logic       verdict_valid,
    input logic       verdict_ok,
    input logic [2:0] verdict_reason
);
    // R1: a closing slot yields a verdict on the next cycle.
    p_verdict_follows_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_last) |=> verdict_valid);

    // R1: no verdict without a closing slot one cycle earlier.
    p_no_stray_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(slot_valid && slot_last));

    // R1: outputs stay at zero between verdicts.
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> (!verdict_ok && verdict_reason == 3'd0));

    // R4: an illegal digit on source 0 of the closing slot forces reason 5.
    p_bad_swz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_last && slot_nsrc != 2'd0 && slot_swz[1:0] == 2'd3)
        |=> verdict_reason == 3'd5);

    // R10: reason codes stay within the defined set.
    p_reason_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> verdict_reason <= 3'd5);

    // R10: the ok flag agrees with a zero reason.
    p_ok_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> (verdict_ok == (verdict_reason == 3'd0)));
endmodule

bind alu_group_port_check alu_group_port_check_sva u_sva (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_last(slot_last),
    .slot_nsrc(slot_nsrc), .slot_swz(slot_swz), .verdict_valid(verdict_valid),
    .verdict_ok(verdict_ok), .verdict_reason(verdict_reason)
);

// File: tb/tb_alu_group_port_check.sv
`timescale 1ns/1ps
module tb_alu_group_port_check;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_valid = 1'b0, slot_last = 1'b0, slot_trans = 1'b0;
    logic [1:0] slot_nsrc = '0;
    logic [23:0] slot_sel = '0;
    logic [5:0]  slot_elem = '0, slot_swz = '0;
    logic        verdict_valid, verdict_ok;
    logic [2:0]  verdict_reason;

    int n_cmp = 0, n_bad = 0;

    int g_n;
    int g_tr  [5];
    int g_ns  [5];
    int g_sel [5][3];
    int g_el  [5][3];
    int g_dg  [5][3];

    always #2 clk = ~clk;

    alu_group_port_check dut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_last(slot_last),
        .slot_trans(slot_trans), .slot_nsrc(slot_nsrc), .slot_sel(slot_sel),
        .slot_elem(slot_elem), .slot_swz(slot_swz), .verdict_valid(verdict_valid),
        .verdict_ok(verdict_ok), .verdict_reason(verdict_reason)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_cmp++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_group();
        g_n = 0;
    endtask

    task automatic add_slot(input int tr, input int ns,
                            input int s0, input int e0, input int d0,
                            input int s1, input int e1, input int d1,
                            input int s2, input int e2, input int d2);
        g_tr[g_n] = tr; g_ns[g_n] = ns;
        g_sel[g_n][0] = s0; g_el[g_n][0] = e0; g_dg[g_n][0] = d0;
        g_sel[g_n][1] = s1; g_el[g_n][1] = e1; g_dg[g_n][1] = d1;
        g_sel[g_n][2] = s2; g_el[g_n][2] = e2; g_dg[g_n][2] = d2;
        g_n++;
    endtask

    // Independent model: pairwise comparison over the whole group.
    function automatic int model_reason();
        int  ps [15], pe [15], pd [15];
        bit  pa [15], pk [15];
        bit  f_swz = 0, f_port = 0, f_gpr = 0, f_con = 0, f_tr = 0;
        int  ng = 0, nc = 0;
        for (int s = 0; s < g_n; s++) begin
            for (int i = 0; i < 3; i++) begin
                int p = s*3 + i;
                ps[p] = g_sel[s][i]; pe[p] = g_el[s][i]; pd[p] = g_dg[s][i];
                pa[p] = i < g_ns[s];
                pk[p] = (i == 1) && g_ns[s] >= 2 && g_sel[s][0] < 128 &&
                        g_sel[s][0] == g_sel[s][1] && g_el[s][0] == g_el[s][1];
                if (pa[p] && !pk[p] && pd[p] == 3) f_swz = 1;
            end
        end
        for (int p = 0; p < g_n*3; p++) begin
            bit seen = 0;
            if (pa[p] && !pk[p] && ps[p] < 128 && pd[p] != 3)
                for (int q = 0; q < p; q++)
                    if (pa[q] && !pk[q] && ps[q] < 128 && pd[q] == pd[p] &&
                        pe[q] == pe[p] && ps[q] != ps[p]) f_port = 1;
            if (pa[p] && ps[p] < 128) begin
                for (int q = 0; q < p; q++)
                    if (pa[q] && ps[q] == ps[p]) seen = 1;
                if (!seen) ng++;
            end
            seen = 0;
            if (pa[p] && ps[p] >= 128 && ps[p] < 192) begin
                for (int q = 0; q < p; q++)
                    if (pa[q] && ps[q] == ps[p] && pe[q] == pe[p]) seen = 1;
                if (!seen) nc++;
            end
        end
        f_gpr = ng > 3;
        f_con = nc > 4;
        for (int s = 0; s < g_n; s++) begin
            int k = 0;
            if (g_tr[s] == 0) continue;
            for (int i = 0; i < g_ns[s]; i++)
                if (g_sel[s][i] >= 128 && g_sel[s][i] < 254) k++;
            for (int i = 0; i < g_ns[s]; i++) begin
                int p = s*3 + i;
                if (!pk[p] && pd[p] != 3 && (ps[p] < 128 || ps[p] >= 254)) begin
                    if (k == 1 && pd[p] == 0) f_tr = 1;
                    if (k == 2 && pd[p] != 2) f_tr = 1;
                end
            end
        end
        if (f_swz)  return 5;
        if (f_port) return 1;
        if (f_gpr)  return 2;
        if (f_con)  return 3;
        if (f_tr)   return 4;
        return 0;
    endfunction

    // Drive the stored group and compare the verdict in its due cycle.
    task automatic run_group(input int exp, input string req);
        for (int s = 0; s < g_n; s++) begin
            slot_valid = 1'b1;
            slot_last  = (s == g_n - 1);
            slot_trans = g_tr[s][0];
            slot_nsrc  = 2'(g_ns[s]);
            slot_sel   = {8'(g_sel[s][2]), 8'(g_sel[s][1]), 8'(g_sel[s][0])};
            slot_elem  = {2'(g_el[s][2]), 2'(g_el[s][1]), 2'(g_el[s][0])};
            slot_swz   = {2'(g_dg[s][2]), 2'(g_dg[s][1]), 2'(g_dg[s][0])};
            @(negedge clk);
        end
        check(verdict_valid && int'(verdict_reason) == exp && verdict_ok == (exp == 0),
              req, verdict_valid ? int'(verdict_reason) : -1, exp);
        slot_valid = 1'b0; slot_last = 1'b0; slot_trans = 1'b0;
        @(negedge clk);
        check(!verdict_valid && verdict_reason == 3'd0 && !verdict_ok,
              "R1 pulse", int'(verdict_valid), 0);
    endtask

    function automatic int pick_sel(input int r);
        case (r)
            0: return 0;   1: return 1;   2: return 2;   3: return 3;
            4: return 130; 5: return 131; 6: return 140; 7: return 165;
            8: return 250; default: return 254;
        endcase
    endfunction

    initial begin
        #(4*150000);
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: nothing pending out of reset
        check(!verdict_valid && verdict_reason == 3'd0 && !verdict_ok, "R2 reset", int'(verdict_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 sharing and conflict, incl. trans slot on shared ports
        clear_group(); add_slot(0,1, 1,0,0, 0,0,0, 0,0,0); add_slot(0,1, 1,0,0, 0,0,0, 0,0,0); run_group(0, "R5 share");
        clear_group(); add_slot(0,1, 1,0,0, 0,0,0, 0,0,0); add_slot(0,1, 2,0,0, 0,0,0, 0,0,0); run_group(1, "R5 conflict");
        // R12: clean group after a faulty one
        clear_group(); add_slot(0,1, 1,0,0, 0,0,0, 0,0,0); add_slot(0,1, 2,0,1, 0,0,0, 0,0,0); run_group(0, "R12 fresh");
        clear_group(); add_slot(0,1, 1,0,0, 0,0,0, 0,0,0); add_slot(1,1, 2,0,0, 0,0,0, 0,0,0); run_group(1, "R5 trans port");
        // R4 digit mapping
        clear_group(); add_slot(0,2, 3,0,2, 1,1,0, 0,0,0); run_group(0, "R4 digits");
        clear_group(); add_slot(0,2, 3,0,2, 1,0,2, 0,0,0); run_group(1, "R4 same cycle");
        // R6 squaring
        clear_group(); add_slot(0,2, 5,2,1, 5,2,3, 0,0,0); run_group(0, "R6 square");
        clear_group(); add_slot(0,2, 5,2,1, 5,1,3, 0,0,0); run_group(5, "R6 not square");
        // R3 non-GPR operands use no ports
        clear_group(); add_slot(0,3, 250,0,0, 254,0,0, 130,0,0); add_slot(0,2, 1,0,0, 192,0,0, 0,0,0); run_group(0, "R3 classes");
        // R7, R8
        clear_group(); add_slot(0,3, 0,0,0, 1,1,1, 2,2,2); add_slot(0,1, 3,3,0, 0,0,0, 0,0,0); run_group(2, "R7 gprs");
        clear_group(); add_slot(0,3, 130,0,0, 130,1,0, 130,2,0); add_slot(0,2, 131,0,0, 131,1,0, 0,0,0); run_group(3, "R8 consts");
        // R9 trans timing
        clear_group(); add_slot(1,2, 130,0,0, 1,0,0, 0,0,0); run_group(4, "R9 one const c0");
        clear_group(); add_slot(1,2, 130,0,0, 1,0,1, 0,0,0); run_group(0, "R9 one const c1");
        clear_group(); add_slot(1,3, 130,0,0, 131,1,0, 1,2,1); run_group(4, "R9 two const c1");
        clear_group(); add_slot(1,3, 130,0,0, 131,1,0, 1,2,2); run_group(0, "R9 two const c2");
        clear_group(); add_slot(1,3, 130,0,0, 250,1,0, 254,0,1); run_group(4, "R9 prev c1");
        // R10 priority
        clear_group(); add_slot(0,1, 1,0,0, 0,0,0, 0,0,0); add_slot(0,2, 2,0,0, 130,0,3, 0,0,0); run_group(5, "R10 swz over port");
        clear_group(); add_slot(0,3, 0,0,0, 1,0,0, 2,1,1); add_slot(0,1, 3,3,2, 0,0,0, 0,0,0); run_group(1, "R10 port over gprs");
        // R11 inactive sources ignored
        clear_group(); add_slot(0,1, 1,0,0, 2,0,3, 3,0,3); run_group(0, "R11 nsrc");

        // Exhaustive single-slot sweep (R4, R5, R6, R9)
        for (int a = 0; a < 1024; a++) begin
            int s0 = a & 1, s1, e0 = (a>>3)&1, e1 = (a>>4)&1, d0 = (a>>5)&3, d1 = (a>>7)&3, tr = (a>>9)&1;
            case ((a>>1)&3) 0: s1 = 0; 1: s1 = 1; 2: s1 = 130; default: s1 = 254; endcase
            clear_group(); add_slot(tr,2, s0,e0,d0, s1,e1,d1, 0,0,0);
            run_group(model_reason(), "R4 R5 R6 R9 sweep");
        end

        // Random multi-slot groups (R3, R5, R7, R8, R9, R10, R11, R12)
        void'($urandom(7));
        for (int g = 0; g < 2000; g++) begin
            int n = 1 + $urandom % 5;
            clear_group();
            for (int s = 0; s < n; s++) begin
                int v [9];
                for (int i = 0; i < 3; i++) begin
                    v[i*3]   = pick_sel($urandom % 10);
                    v[i*3+1] = $urandom % 4;
                    v[i*3+2] = ($urandom % 10 == 0) ? 3 : $urandom % 3;
                end
                if ($urandom % 4 == 0) begin v[3] = v[0]; v[4] = v[1]; end
                add_slot((s == n-1) ? $urandom % 2 : 0, $urandom % 4,
                         v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7], v[8]);
            end
            run_group(model_reason(), "R10 random group");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule